// File: doc/BRIEF.md
# Acknowledge-Driven Call Vector Sequencer

This block sits on the CPU side of an interrupt controller and answers the acknowledge cycle. The acknowledge is a train of three pulses. The block counts them and drives one byte of a three-byte call instruction onto the 8-bit data bus during each pulse. The first byte is the fixed call opcode. The second is the low byte of the service routine address. The third is the programmed high address byte.

The low byte combines two sources. Its upper bits come from a programmed value. Its lower bits are built from the index of the request being serviced. A spacing select sets where the index is placed:

- With spacing 4, the index sits just above two zero bits.
- With spacing 8, the index sits just above three zero bits.

The request index is captured at the start of the first pulse. Requests that change later in the cycle cannot alter the vector. After the third pulse ends, the block raises a one-cycle end strobe, which an automatic end-of-interrupt mechanism can use.

Top module: `vector_call_seq`

## Requirements
- R1: After reset, `bus_oe` is low, `bus_data` is 0 and `seq_done` is low, and the next acknowledge pulse is treated as the first of a cycle.
- R2: `bus_oe` is high exactly while `ack` is high. `bus_data` is 0 whenever `ack` is low.
- R3: During the first pulse of a cycle, `bus_data` is 8'hCD (binary 11001101).
- R4: During the second pulse with `spacing8` = 0, `bus_data` = {`vec_lo_prog`[7:5], captured index[2:0], 2'b00}.
- R5: During the second pulse with `spacing8` = 1, `bus_data` = {`vec_lo_prog`[7:6], captured index[2:0], 3'b000}.
- R6: During the third pulse, `bus_data` equals `vec_hi`.
- R7: The index is sampled in the cycle in which the first pulse rises. Later changes on `req_idx` have no effect on the low byte of that cycle.
- R8: After the third pulse falls, `seq_done` is high for exactly one cycle. That cycle follows the clock in which the low level is sampled. The next pulse then carries the opcode again.
- R9: `seq_done` never rises after the first or second pulse.
- R10: A pulse held high for several cycles counts once, and `bus_data` stays stable for the whole pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack | input | 1 | Acknowledge strobe, active high, synchronous to clk |
| req_idx | input | 3 | Index of the request being serviced |
| vec_lo_prog | input | 8 | Programmed low address byte; only its upper bits are used |
| vec_hi | input | 8 | Programmed high address byte |
| spacing8 | input | 1 | 1 selects vector spacing 8, 0 selects spacing 4 |
| bus_data | output | 8 | Byte driven for the current pulse |
| bus_oe | output | 1 | Data bus drive enable |
| seq_done | output | 1 | One-cycle end-of-sequence strobe |

## Verification
The checker makes three assumptions about the inputs:

- `vec_lo_prog`, `vec_hi` and `spacing8` do not change while a pulse is high.
- Each pulse is low for at least one sampled clock before the next one rises.
- The three pulses of one cycle are never mixed with reset.

The stimulus changes programming only between cycles and always leaves at least two low cycles between pulses. It deliberately changes `req_idx` during a cycle, because the design must tolerate that. Pulse widths of one to several cycles show that a long pulse still counts as a single slot.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

   typedef enum logic [1:0] {
      SLOT_OPC = 2'd0,
      SLOT_LO  = 2'd1,
      SLOT_HI  = 2'd2
   } slot_e;

   function automatic slot_e slot_after(input slot_e s);
      case (s)
         SLOT_OPC: slot_after = SLOT_LO;
         SLOT_LO:  slot_after = SLOT_HI;
         default:  slot_after = SLOT_OPC;
      endcase
   endfunction

endpackage

// File: rtl/vseq_pulse_ctr.sv
module vseq_pulse_ctr
   import vseq_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack,
   input  logic [IDX_W-1:0] idx_in,
   output slot_e            slot,
   output logic [IDX_W-1:0] idx_q,
   output logic             done
);

   logic ack_q;
   logic rise;
   logic fall;

   assign rise = ack & ~ack_q;
   assign fall = ~ack & ack_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         slot  <= SLOT_OPC;
         idx_q <= '0;
         done  <= 1'b0;
      end else begin
         ack_q <= ack;
         done  <= fall && (slot == SLOT_HI);
         if (fall) begin
            slot <= slot_after(slot);
         end
         if (rise && (slot == SLOT_OPC)) begin
            idx_q <= idx_in;
         end
      end
   end

endmodule

// File: rtl/vseq_lo_byte.sv
module vseq_lo_byte #(
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic [BYTE_W-1:0] prog,
   input  logic [IDX_W-1:0]  idx,
   input  logic              spacing8,
   output logic [BYTE_W-1:0] lo_byte
);

   localparam int SH4 = 2;
   localparam int SH8 = 3;
   localparam int TOP4 = IDX_W + SH4;
   localparam int TOP8 = IDX_W + SH8;

   logic [BYTE_W-1:0] v4;
   logic [BYTE_W-1:0] v8;

   for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      if (b >= TOP4) begin : g_p4
         assign v4[b] = prog[b];
      end else if (b >= SH4) begin : g_i4
         assign v4[b] = idx[b-SH4];
      end else begin : g_z4
         assign v4[b] = 1'b0;
      end
      if (b >= TOP8) begin : g_p8
         assign v8[b] = prog[b];
      end else if (b >= SH8) begin : g_i8
         assign v8[b] = idx[b-SH8];
      end else begin : g_z8
         assign v8[b] = 1'b0;
      end
   end

   assign lo_byte = spacing8 ? v8 : v4;

endmodule

// File: rtl/vseq_bus_mux.sv
module vseq_bus_mux
   import vseq_pkg::*;
#(
   parameter int          BYTE_W = 8,
   parameter logic [7:0]  OPCODE = 8'hCD
) (
   input  logic              ack,
   input  slot_e             slot,
   input  logic [BYTE_W-1:0] lo_byte,
   input  logic [BYTE_W-1:0] hi_byte,
   output logic [BYTE_W-1:0] data,
   output logic              oe
);

   logic [BYTE_W-1:0] sel;

   always_comb begin
      case (slot)
         SLOT_OPC: sel = BYTE_W'(OPCODE);
         SLOT_LO:  sel = lo_byte;
         default:  sel = hi_byte;
      endcase
   end

   assign data = ack ? sel : '0;
   assign oe   = ack;

endmodule

// File: rtl/vector_call_seq.sv
module vector_call_seq
   import vseq_pkg::*;
#(
   parameter int          BYTE_W = 8,
   parameter int          IDX_W  = 3,
   parameter logic [7:0]  OPCODE = 8'hCD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [BYTE_W-1:0] vec_lo_prog,
   input  logic [BYTE_W-1:0] vec_hi,
   input  logic              spacing8,
   output logic [BYTE_W-1:0] bus_data,
   output logic              bus_oe,
   output logic              seq_done
);

   localparam int MIN_BYTE_W = IDX_W + 4;

   if (IDX_W < 1) begin : g_bad_idx
      $error("vector_call_seq: IDX_W must be at least 1");
   end
   if (BYTE_W < MIN_BYTE_W) begin : g_bad_byte
      $error("vector_call_seq: BYTE_W too small for index field and programmed bit");
   end

   slot_e             slot;
   logic [IDX_W-1:0]  idx_q;
   logic [BYTE_W-1:0] lo_byte;

   vseq_pulse_ctr #(.IDX_W(IDX_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ack    (ack),
      .idx_in (req_idx),
      .slot   (slot),
      .idx_q  (idx_q),
      .done   (seq_done)
   );

   vseq_lo_byte #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_lo (
      .prog     (vec_lo_prog),
      .idx      (idx_q),
      .spacing8 (spacing8),
      .lo_byte  (lo_byte)
   );

   vseq_bus_mux #(.BYTE_W(BYTE_W), .OPCODE(OPCODE)) u_mux (
      .ack     (ack),
      .slot    (slot),
      .lo_byte (lo_byte),
      .hi_byte (vec_hi),
      .data    (bus_data),
      .oe      (bus_oe)
   );

endmodule

// File: rtl/vector_call_seq_chk.sv
module vector_call_seq_chk #(
   parameter int          BYTE_W = 8,
   parameter logic [7:0]  OPCODE = 8'hCD
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic [BYTE_W-1:0] vec_hi,
   input logic [BYTE_W-1:0] bus_data,
   input logic              seq_done
);

   logic [1:0] seen;
   logic       ack_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen  <= 2'd0;
         ack_d <= 1'b0;
      end else begin
         ack_d <= ack;
         if (!ack && ack_d) begin
            seen <= (seen == 2'd2) ? 2'd0 : seen + 2'd1;
         end
      end
   end

   // R3
   opcode_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && seen == 2'd0) |-> bus_data == BYTE_W'(OPCODE));

   // R6
   high_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && seen == 2'd2) |-> bus_data == vec_hi);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);

   // R9
   done_after_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> (seen == 2'd0 && !ack_d));

   // R10
   pulse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ack_d) |-> $stable(bus_data));

endmodule

bind vector_call_seq vector_call_seq_chk #(.BYTE_W(BYTE_W), .OPCODE(OPCODE)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ack      (ack),
   .vec_hi   (vec_hi),
   .bus_data (bus_data),
   .seq_done (seq_done)
);

// File: tb/vector_call_seq_test.sv
module vector_call_seq_test;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [7:0] val;
      string      req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ack = 1'b0;
   logic [2:0] req_idx = '0;
   logic [7:0] vec_lo_prog = '0;
   logic [7:0] vec_hi = '0;
   logic       spacing8 = 1'b0;
   logic [7:0] bus_data;
   logic       bus_oe;
   logic       seq_done;

   int checks = 0;
   int errors = 0;
   item_t exp_q[$];
   logic  oe_prev = 1'b0;
   logic [7:0] held = '0;
   string held_req = "";

   always #(CLK_PERIOD/2) clk = ~clk;

   vector_call_seq uut (
      .clk(clk), .rst_n(rst_n), .ack(ack), .req_idx(req_idx),
      .vec_lo_prog(vec_lo_prog), .vec_hi(vec_hi), .spacing8(spacing8),
      .bus_data(bus_data), .bus_oe(bus_oe), .seq_done(seq_done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] lo_ref(input logic [7:0] p, input logic [2:0] i, input logic s8);
      return s8 ? {p[7:6], i, 3'b000} : {p[7:5], i, 2'b00};
   endfunction

   // monitor: first sample of each pulse pops an expected byte; later samples check stability
   always @(negedge clk) begin
      if (bus_oe && !oe_prev) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected pulse", bus_data, 0);
         end else begin
            item_t it;
            it = exp_q.pop_front();
            check(bus_data == it.val, it.req, bus_data, it.val);
            held = bus_data;
            held_req = it.req;
         end
      end else if (bus_oe) begin
         check(bus_data == held, "R10 stable during pulse", bus_data, held);
      end
      oe_prev = bus_oe;
   end

   task automatic pulse(input int hold, input bit last);
      @(posedge clk); #1 ack = 1'b1;
      repeat (hold) @(posedge clk);
      #1 ack = 1'b0;
      @(negedge clk);
      check(!bus_oe && bus_data == 8'h00, "R2 idle bus", {bus_oe, bus_data}, 0);
      @(posedge clk); @(negedge clk);
      if (last) check(seq_done == 1'b1, "R8 done after third", seq_done, 1);
      else      check(seq_done == 1'b0, "R9 no done early", seq_done, 0);
      @(posedge clk); @(negedge clk);
      check(seq_done == 1'b0, "R8 done one cycle", seq_done, 0);
   endtask

   task automatic run_seq(input logic [7:0] p, input logic [7:0] h, input logic s8,
                          input logic [2:0] i, input logic [2:0] i_late, input int hold);
      item_t it;
      vec_lo_prog = p; vec_hi = h; spacing8 = s8; req_idx = i;
      it.val = 8'hCD; it.req = "R3 opcode"; exp_q.push_back(it);
      it.val = lo_ref(p, i, s8);
      it.req = s8 ? "R5 low byte spacing8 / R7" : "R4 low byte spacing4 / R7";
      exp_q.push_back(it);
      it.val = h; it.req = "R6 high byte"; exp_q.push_back(it);
      pulse(hold, 1'b0);
      req_idx = i_late;
      pulse(hold, 1'b0);
      pulse(hold, 1'b1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!bus_oe && bus_data == 8'h00 && !seq_done, "R1 reset state",
            {seq_done, bus_oe, bus_data}, 0);
      run_seq(8'hA0, 8'h3C, 1'b0, 3'd5, 3'd5, 1);
      run_seq(8'hC0, 8'h12, 1'b1, 3'd6, 3'd6, 2);
      run_seq(8'h5F, 8'hFF, 1'b0, 3'd0, 3'd7, 1);
      run_seq(8'h5F, 8'h80, 1'b1, 3'd7, 3'd0, 3);
      // R7 index changes after capture
      run_seq(8'hE0, 8'h01, 1'b0, 3'd3, 3'd1, 4);
      run_seq(8'h00, 8'hA5, 1'b1, 3'd2, 3'd4, 1);
      repeat (2) @(posedge clk);
      check(exp_q.size() == 0, "R2 all pulses seen", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule